// File: doc/BRIEF.md
# Signed 18x18 Multiplier with Optional Output Register

This block forms the exact 36-bit two's-complement product of two 18-bit two's-complement operands. An elaboration-time parameter chooses the output style. In combinational mode the product follows the operands directly. In registered mode a single output register holds the product.

The output register has a clock enable and a synchronous clear. The clear acts only on an edge where the enable is active, and it wins over loading a new product. Separate parameters select inverted polarity for the clock, the enable and the clear. An inverted clock makes the register capture on the falling edge. An asynchronous active-low reset puts the register at zero from power-up.

To multiply unsigned values, the caller zero-extends operands of up to 17 bits into the signed inputs. The sign bit is then 0, so the signed product equals the unsigned product.

Top module: `mul18_sreg`

## Requirements
- R1: `p_o` equals the signed product of `a_i` and `b_i`, both read as 18-bit two's complement, and the result is exact over the full 36 bits. For example, -131072 x -131072 gives 36'h4_0000_0000, 131071 x -131072 gives -17179738112, and 0 times any operand gives 0.
- R2: Two unsigned operands of up to 17 bits, zero-extended into bit 17, give their unsigned product. For example, 131071 x 131071 gives 17179607041.
- R3: With `REGISTERED`=0, `p_o` follows the operands with no clock edge involved.
- R4: With `REGISTERED`=1, the register samples the operands at an active clock edge where the enable is active. The product is on `p_o` after that edge and does not follow later changes of the operands.
- R5: On an active edge where the enable is inactive, `p_o` keeps its value, whatever the operands and the clear input are.
- R6: A clear on an edge where the enable is active sets `p_o` to zero. A clear on an edge where the enable is inactive has no effect.
- R7: When clear and enable are both active on the same edge, the result is zero even when the operands are nonzero.
- R8: With `CLK_INV`=1 the register captures on the falling edge of `clk_i`. With `CE_INV`=1 the enable is active when `ce_i` is 0. With `SRST_INV`=1 the clear is active when `srst_i` is 0.
- R9: While `rst_ni` is 0, `p_o` is zero, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the active edge is chosen by `CLK_INV` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for the output register; polarity chosen by `CE_INV` |
| srst_i | input | 1 | Synchronous clear of the output register; polarity chosen by `SRST_INV` |
| a_i | input | 18 | First operand, two's complement |
| b_i | input | 18 | Second operand, two's complement |
| p_o | output | 36 | Product |

## Verification
The only state is the output register, so a wrong value in it appears on `p_o` right after the active edge that wrote it. It stays there until the next enabled edge. A fault in sign handling or product width shows at once on the extreme operands, even in combinational mode. A wrong priority between clear and load, or a clear that acts while the enable is off, shows as a nonzero or as a cleared `p_o` one edge after the stimulus. A wrong polarity setting shows as a capture on the wrong edge, half a period early or late.

// File: rtl/mul18_pkg.sv
`timescale 1ns/1ps
package mul18_pkg;
  localparam int unsigned OP_W = 18;
  localparam int unsigned PR_W = 2 * OP_W;
  typedef logic signed [OP_W-1:0] op_t;
  typedef logic signed [PR_W-1:0] prod_t;
endpackage

// File: rtl/mul18_core.sv
`timescale 1ns/1ps
module mul18_core #(
  parameter int unsigned A_W = 18,
  parameter int unsigned B_W = 18,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  logic signed [P_W-1:0] a_ext, b_ext;

  // sign-extend to full width so the product is exact
  assign a_ext = P_W'($signed(a_i));
  assign b_ext = P_W'($signed(b_i));
  assign p_o   = a_ext * b_ext;

  always_comb begin
    if (a_i != '0 && b_i != '0) begin
      p_sign_r1: assert (p_o[P_W-1] == (a_i[A_W-1] ^ b_i[B_W-1]))
        else $error("product sign mismatch");
    end
  end
endmodule

// File: rtl/mul18_ctl_pol.sv
`timescale 1ns/1ps
module mul18_ctl_pol #(
  parameter bit CLK_INV  = 1'b0,
  parameter bit CE_INV   = 1'b0,
  parameter bit SRST_INV = 1'b0
) (
  input  logic clk_i,
  input  logic ce_i,
  input  logic srst_i,
  output logic clk_o,
  output logic ce_o,
  output logic clr_o
);
  if (CLK_INV) begin : g_clk_inv
    assign clk_o = ~clk_i;
  end else begin : g_clk_dir
    assign clk_o = clk_i;
  end

  if (CE_INV) begin : g_ce_inv
    assign ce_o = ~ce_i;
  end else begin : g_ce_dir
    assign ce_o = ce_i;
  end

  if (SRST_INV) begin : g_srst_inv
    assign clr_o = ~srst_i;
  end else begin : g_srst_dir
    assign clr_o = srst_i;
  end
endmodule

// File: rtl/mul18_out_reg.sv
`timescale 1ns/1ps
module mul18_out_reg #(
  parameter int unsigned P_W = 36
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ce_i,
  input  logic           clr_i,
  input  logic [P_W-1:0] d_i,
  output logic [P_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (ce_i)  q_o <= clr_i ? '0 : d_i;  // clear wins over load
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(q_o));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && clr_i) |=> (q_o == '0));
  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !clr_i) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/mul18_sreg.sv
`timescale 1ns/1ps
module mul18_sreg
  import mul18_pkg::*;
#(
  parameter bit REGISTERED = 1'b1,
  parameter bit CLK_INV    = 1'b0,
  parameter bit CE_INV     = 1'b0,
  parameter bit SRST_INV   = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_i,
  input  logic            srst_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [PR_W-1:0] p_o
);
  logic [PR_W-1:0] prod;

  mul18_core #(.A_W(OP_W), .B_W(OP_W)) i_core (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (prod)
  );

  if (REGISTERED) begin : g_reg
    logic clk_eff, ce_eff, clr_eff;

    mul18_ctl_pol #(
      .CLK_INV (CLK_INV),
      .CE_INV  (CE_INV),
      .SRST_INV(SRST_INV)
    ) i_pol (
      .clk_i (clk_i),
      .ce_i  (ce_i),
      .srst_i(srst_i),
      .clk_o (clk_eff),
      .ce_o  (ce_eff),
      .clr_o (clr_eff)
    );

    mul18_out_reg #(.P_W(PR_W)) i_oreg (
      .clk_i (clk_eff),
      .rst_ni(rst_ni),
      .ce_i  (ce_eff),
      .clr_i (clr_eff),
      .d_i   (prod),
      .q_o   (p_o)
    );
  end else begin : g_comb
    assign p_o = prod;
  end
endmodule

// File: tb/test_mul18_sreg.sv
`timescale 1ns/1ps
module test_mul18_sreg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // registered, direct polarity
  logic ce = 1'b0, srst = 1'b0;
  logic [17:0] a = '0, b = '0;
  logic [35:0] p;
  // combinational
  logic [17:0] ca = '0, cb = '0;
  logic [35:0] cp;
  // registered, all controls inverted
  logic ce_n = 1'b1, srst_n = 1'b1;
  logic [17:0] ia = '0, ib = '0;
  logic [35:0] ip;

  mul18_sreg i_mul18_sreg (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .srst_i(srst),
    .a_i(a), .b_i(b), .p_o(p));

  mul18_sreg #(.REGISTERED(1'b0)) i_mul18_sreg_comb (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(1'b0), .srst_i(1'b0),
    .a_i(ca), .b_i(cb), .p_o(cp));

  mul18_sreg #(.CLK_INV(1'b1), .CE_INV(1'b1), .SRST_INV(1'b1)) i_mul18_sreg_inv (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce_n), .srst_i(srst_n),
    .a_i(ia), .b_i(ib), .p_o(ip));

  function automatic logic [35:0] ref_mul(input logic [17:0] x, input logic [17:0] y);
    longint xs, ys, pr;
    xs = longint'($signed(x));
    ys = longint'($signed(y));
    pr = xs * ys;
    return pr[35:0];
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // sample 3 ns after the rising / falling edge
  task automatic after_pos(); @(posedge clk); #3; endtask
  task automatic after_neg(); @(negedge clk); #3; endtask

  task automatic t_reset();
    chk("R9 reset reg", p, '0);
    chk("R9 reset inv", ip, '0);
  endtask

  task automatic load(input logic [17:0] x, input logic [17:0] y);
    a = x; b = y; ce = 1'b1; srst = 1'b0;
    after_pos();
  endtask

  task automatic t_corners();
    load(18'h20000, 18'h20000); chk("R1 min*min", p, 36'h4_0000_0000);
    load(18'h1FFFF, 18'h20000); chk("R1 max*min", p, ref_mul(18'h1FFFF, 18'h20000));
    chk("R1 max*min const", p, 36'(-64'sd17179738112));
    load(18'h00000, 18'h2ABCD); chk("R1 zero", p, '0);
    load(18'h3FFFF, 18'h3FFFF); chk("R1 -1*-1", p, 36'd1);
    load(18'h1FFFF, 18'h1FFFF); chk("R1 max*max", p, 36'd17179607041);
  endtask

  task automatic t_unsigned();
    load({1'b0, 17'h1FFFF}, {1'b0, 17'h1FFFF}); chk("R2 unsigned max", p, 36'd17179607041);
    load({1'b0, 17'h10000}, {1'b0, 17'h00003}); chk("R2 unsigned", p, 36'd196608);
  endtask

  task automatic t_comb();
    ca = 18'h20000; cb = 18'h20000; #1; chk("R3 comb min*min", cp, 36'h4_0000_0000);
    ca = 18'h00007; cb = 18'h3FFFD; #1; chk("R3 comb 7*-3", cp, 36'(-64'sd21));
    ca = 18'h12345; cb = 18'h00100; #1; chk("R3 comb", cp, ref_mul(18'h12345, 18'h00100));
  endtask

  task automatic t_latency();
    a = 18'h00011; b = 18'h00002; ce = 1'b1; srst = 1'b0;
    @(posedge clk); #1;
    a = 18'h00005; b = 18'h00005;   // changed after the edge
    #2; chk("R4 sampled at edge", p, 36'd34);
    ce = 1'b0;
    after_pos(); chk("R4 no follow", p, 36'd34);
  endtask

  task automatic t_hold();
    load(18'h00009, 18'h00009);
    ce = 1'b0; a = 18'h00123; b = 18'h3FF00;
    after_pos(); chk("R5 hold 1", p, 36'd81);
    a = 18'h20000;
    after_pos(); chk("R5 hold 2", p, 36'd81);
  endtask

  task automatic t_srst();
    load(18'h00004, 18'h00005);
    ce = 1'b0; srst = 1'b1;
    after_pos(); chk("R6 clear ignored without enable", p, 36'd20);
    ce = 1'b1; srst = 1'b0; a = 18'h00003; b = 18'h00003;
    after_pos(); chk("R6 reload", p, 36'd9);
    srst = 1'b1; a = 18'h0000A; b = 18'h0000A;
    after_pos(); chk("R7 clear over load", p, '0);
    srst = 1'b0;
    after_pos(); chk("R6 load after clear", p, 36'd100);
  endtask

  task automatic t_inv();
    after_neg();
    ia = 18'h00006; ib = 18'h00007; ce_n = 1'b0; srst_n = 1'b1;
    after_pos(); chk("R8 no capture on rising", ip, '0);
    after_neg(); chk("R8 capture on falling", ip, 36'd42);
    ce_n = 1'b1; ia = 18'h00002;
    after_neg(); chk("R8 enable low-active hold", ip, 36'd42);
    srst_n = 1'b0;
    after_neg(); chk("R8 clear ignored without enable", ip, 36'd42);
    ce_n = 1'b0;
    after_neg(); chk("R8 clear low-active", ip, '0);
    srst_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [17:0] x, y;
      x = 18'($urandom); y = 18'($urandom);
      load(x, y);
      chk("R1 random", p, ref_mul(x, y));
    end
  endtask

  task automatic t_async();
    load(18'h00003, 18'h00007);
    #1 rst_n = 1'b0; #1;
    chk("R9 async clear reg", p, '0);
    chk("R9 async clear inv", ip, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #1;
    t_reset();
    #20; @(negedge clk); rst_n = 1'b1;
    t_corners();
    t_unsigned();
    t_comb();
    t_latency();
    t_hold();
    t_srst();
    t_inv();
    t_random();
    t_async();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule